// File: doc/BRIEF.md
# BCH Sector Post-Decode Fixup Engine

This engine finishes the decode of one 512-byte flash sector that carries a BCH code, in either the strength-8 layout (14 stored code bytes, the last one reserved) or the strength-16 layout (26 stored code bytes). The sector data and its stored code bytes sit in an internal buffer that the host fills and reads through a byte port. The code bytes computed while reading the sector are loaded into a separate bank. That bank also presents them in reversed byte order, which is the form an external error locator expects.

When `start` is pulsed, the engine inspects the computed code. If every active computed byte is zero, the sector may be an erased page. The engine counts the zero bits across the data and the stored code bytes. When that count is at most the strength, it rewrites every byte to 0xFF and reports the count as corrected flips. Otherwise it accepts bit-error locations from the locator, one per cycle over a valid/ready handshake. Each location is counted backwards from the end of the protected span and mapped to a buffer byte and bit, and that bit is inverted in place. A location beyond the span, or a failure beat from the locator, raises the failure flag.

Top module: `sector_fixup`

## Requirements
- R1: After reset, `busy`, `done`, `loc_ready` and `fail` are 0 and `flips` is 0.
- R2: On `start`, the erased-page path is taken only if all active computed code bytes (indices 0..13 in strength-8 mode, 0..25 in strength-16 mode) are zero. Otherwise the engine enters the location phase and raises `loc_ready`, and the buffer is not rewritten.
- R3: A sector whose data and stored code bytes are all 0xFF, with a zero computed code, completes with `flips`=0, `fail`=0 and the buffer unchanged.
- R4: On the erased-page path, zero bits are counted over buffer addresses 0..511 and the stored code bytes at 512..525 (strength 8, reserved byte included) or 512..537 (strength 16). If the count is at most 8 or 16 respectively, all those bytes become 0xFF and `flips` equals the count.
- R5: On the erased-page path with a count above the strength, the buffer is left unchanged and the engine completes with `flips`=0 and `fail`=0.
- R6: `rev_byte` for index i returns computed byte N-1-i when i<N, where N is 13 (strength 8) or 26 (strength 16). In strength-8 mode, index 13 returns computed byte 13 unchanged.
- R7: A location L maps to buffer byte address LIM-1-(L>>3) and bit L%8, with LIM=525 for strength 8 and 538 for strength 16. Addresses 0..511 are data and 512 upward are stored code bytes. That bit is inverted, and `flips` counts each applied inversion.
- R8: A location with (L>>3) >= LIM changes no byte and sets `fail`. Later valid locations in the same list are still applied.
- R9: A beat with `loc_fail`=1 applies no inversion, sets `fail`, and ends the list whether or not `loc_last` is set.
- R10: `loc_ready` is high only during the location phase. A beat with `loc_last` ends the list. `done` is a single-cycle pulse, after which `busy` is 0 and `flips`/`fail` hold until the next `start`.
- R11: Host buffer writes (`host_we`) are ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_t16 | input | 1 | 1 selects strength 16 / 26 code bytes, 0 selects strength 8 / 14 code bytes |
| host_we | input | 1 | Buffer write enable (ignored while busy) |
| host_addr | input | 10 | Buffer write address (0..537) |
| host_wdata | input | 8 | Buffer write data |
| host_raddr | input | 10 | Buffer read address |
| host_rdata | output | 8 | Buffer read data (combinational) |
| calc_we | input | 1 | Computed-code bank write enable |
| calc_idx | input | 5 | Computed-code byte index |
| calc_wdata | input | 8 | Computed-code byte value |
| rev_idx | input | 5 | Index into the reversed computed code |
| rev_byte | output | 8 | Reversed computed-code byte |
| start | input | 1 | Begin processing (accepted when idle) |
| busy | output | 1 | Operation in progress |
| loc_valid | input | 1 | Location beat valid |
| loc_ready | output | 1 | Engine accepts a location beat |
| loc_value | input | 13 | Bit-error location, counted from the end of the span |
| loc_last | input | 1 | Final beat of the list |
| loc_fail | input | 1 | Locator reports an uncorrectable sector |
| done | output | 1 | One-cycle completion pulse |
| flips | output | 13 | Number of corrected bits |
| fail | output | 1 | Invalid location or locator failure seen |

## Verification
The hardest state to reach is the exact boundary of erased-page tolerance. It requires a zero computed code together with a buffer whose zero-bit total lands on the strength or one past it, including bits in the reserved last code byte of the strength-8 layout. The stimulus builds all-0xFF sectors and clears chosen bits in data and code bytes, so the counts are 8 and 9 in strength-8 mode and 5 in strength-16 mode. Span-edge locations are driven directly: the first and last valid location values and the first out-of-range value in each mode, a locator-failure beat in mid-list, and a host write attempted while the engine waits for locations.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  localparam int SECT_BYTES  = 512;
  localparam int ECC_MAX     = 26;
  localparam int ECC8_STORED = 14;
  localparam int ECC8_SPAN   = 13;
  localparam int ECC16_SPAN  = 26;
  localparam int STRENGTH8   = 8;
  localparam int STRENGTH16  = 16;
  localparam int BUF_DEPTH   = SECT_BYTES + ECC_MAX;
  localparam int AW          = $clog2(BUF_DEPTH);
  localparam int LW          = $clog2(BUF_DEPTH * 8);
  localparam int CW          = LW;
  localparam int IW          = $clog2(ECC_MAX);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SCAN, ST_FILL, ST_LOCATE, ST_FINISH
  } sfx_state_t;

  typedef struct packed {
    logic          ok;
    logic [AW-1:0] addr;
    logic [2:0]    bitn;
    logic          in_ecc;
  } fix_t;

  // Location counted from the end of the span -> buffer byte and bit.
  function automatic fix_t map_loc(input logic [LW-1:0] loc, input logic [AW-1:0] limit);
    fix_t f;
    int   back;
    int   pos;
    back     = int'(loc >> 3);
    pos      = int'(limit) - 1 - back;
    f.ok     = back < int'(limit);
    f.bitn   = loc[2:0];
    f.addr   = f.ok ? AW'(pos) : '0;
    f.in_ecc = f.ok && (pos >= SECT_BYTES);
    return f;
  endfunction

  function automatic logic [3:0] zero_bits(input logic [7:0] b);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + {3'b0, ~b[i]};
    return n;
  endfunction
endpackage

// File: rtl/sfx_calc_bank.sv
module sfx_calc_bank #(
  parameter int NB = 26,
  parameter int IW = 5,
  parameter int SPAN_NARROW = 13,
  parameter int STORED_NARROW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    wdata,
  input  logic          wide,
  output logic          all_zero,
  input  logic [IW-1:0] rev_idx,
  output logic [7:0]    rev_byte
);
  logic [7:0] bytes_q [NB];

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         bytes_q[g] <= '0;
        else if (we && int'(idx) == g)      bytes_q[g] <= wdata;
      end
    end
  endgenerate

  always_comb begin
    int active;
    active   = wide ? NB : STORED_NARROW;
    all_zero = 1'b1;
    for (int i = 0; i < NB; i++)
      if (i < active && bytes_q[i] != 8'h00) all_zero = 1'b0;
  end

  always_comb begin
    int nrev;
    int r;
    nrev = wide ? NB : SPAN_NARROW;
    r    = int'(rev_idx);
    if (r < nrev)    rev_byte = bytes_q[nrev - 1 - r];
    else if (r < NB) rev_byte = bytes_q[r];
    else             rev_byte = 8'h00;
  end
endmodule

// File: rtl/sfx_loc_mapper.sv
module sfx_loc_mapper import sfx_pkg::*; (
  input  logic [LW-1:0] loc,
  input  logic [AW-1:0] limit,
  output fix_t          fix
);
  always_comb fix = map_loc(loc, limit);
endmodule

// File: rtl/sfx_sector_buf.sv
module sfx_sector_buf #(
  parameter int DEPTH = 538,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [7:0]    rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [7:0]    rdata_b
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && int'(waddr) < DEPTH) mem[waddr] <= wdata;
  end

  assign rdata_a = (int'(raddr_a) < DEPTH) ? mem[raddr_a] : 8'h00;
  assign rdata_b = (int'(raddr_b) < DEPTH) ? mem[raddr_b] : 8'h00;
endmodule

// File: rtl/sector_fixup.sv
module sector_fixup import sfx_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_t16,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  input  logic [AW-1:0] host_raddr,
  output logic [7:0]    host_rdata,
  input  logic          calc_we,
  input  logic [IW-1:0] calc_idx,
  input  logic [7:0]    calc_wdata,
  input  logic [IW-1:0] rev_idx,
  output logic [7:0]    rev_byte,
  input  logic          start,
  output logic          busy,
  input  logic          loc_valid,
  output logic          loc_ready,
  input  logic [LW-1:0] loc_value,
  input  logic          loc_last,
  input  logic          loc_fail,
  output logic          done,
  output logic [CW-1:0] flips,
  output logic          fail
);
  localparam logic [AW-1:0] LIM8       = AW'(SECT_BYTES + ECC8_SPAN);
  localparam logic [AW-1:0] LIM16      = AW'(SECT_BYTES + ECC16_SPAN);
  localparam logic [AW-1:0] LAST8      = AW'(SECT_BYTES + ECC8_STORED - 1);
  localparam logic [AW-1:0] LAST16     = AW'(SECT_BYTES + ECC16_SPAN - 1);

  sfx_state_t    state;
  logic          mode_q;
  logic [AW-1:0] idx;
  logic [CW-1:0] cnt;
  logic          fail_q;

  logic          calc_zero;
  logic [AW-1:0] limit;
  logic [AW-1:0] scan_last;
  logic [CW-1:0] strength;
  fix_t          fx;
  logic [AW-1:0] int_addr;
  logic [7:0]    int_rdata;
  logic [CW-1:0] scan_sum;

  // Named internal events used by the checker.
  logic          loc_hs;
  logic          fix_we;
  logic          fill_we;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata;

  sfx_calc_bank #(
    .NB(ECC_MAX), .IW(IW), .SPAN_NARROW(ECC8_SPAN), .STORED_NARROW(ECC8_STORED)
  ) u_calc (
    .clk(clk), .rst_n(rst_n), .we(calc_we), .idx(calc_idx), .wdata(calc_wdata),
    .wide(mode_t16), .all_zero(calc_zero), .rev_idx(rev_idx), .rev_byte(rev_byte)
  );

  sfx_loc_mapper u_map (.loc(loc_value), .limit(limit), .fix(fx));

  sfx_sector_buf #(.DEPTH(BUF_DEPTH), .AW(AW)) u_buf (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr_a(host_raddr), .rdata_a(host_rdata),
    .raddr_b(int_addr), .rdata_b(int_rdata)
  );

  assign limit     = mode_q ? LIM16 : LIM8;
  assign scan_last = mode_q ? LAST16 : LAST8;
  assign strength  = mode_q ? CW'(STRENGTH16) : CW'(STRENGTH8);

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FINISH);
  assign loc_ready = (state == ST_LOCATE);
  assign flips     = cnt;
  assign fail      = fail_q;

  assign loc_hs    = loc_valid && loc_ready;
  assign fix_we    = loc_hs && !loc_fail && fx.ok;
  assign fill_we   = (state == ST_FILL);
  assign int_addr  = (state == ST_LOCATE) ? fx.addr : idx;
  assign scan_sum  = cnt + CW'(zero_bits(int_rdata));

  always_comb begin
    if (busy) begin
      mem_we    = fix_we || fill_we;
      mem_waddr = int_addr;
      mem_wdata = fill_we ? 8'hFF : (int_rdata ^ (8'h01 << fx.bitn));
    end else begin
      mem_we    = host_we;
      mem_waddr = host_addr;
      mem_wdata = host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mode_q <= 1'b0;
      idx    <= '0;
      cnt    <= '0;
      fail_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          mode_q <= mode_t16;
          idx    <= '0;
          cnt    <= '0;
          fail_q <= 1'b0;
          state  <= calc_zero ? ST_SCAN : ST_LOCATE;
        end
        ST_SCAN: begin
          cnt <= scan_sum;
          idx <= idx + 1'b1;
          if (idx == scan_last) begin
            idx <= '0;
            if (scan_sum <= strength) state <= ST_FILL;
            else begin
              cnt   <= '0;
              state <= ST_FINISH;
            end
          end
        end
        ST_FILL: begin
          idx <= idx + 1'b1;
          if (idx == scan_last) state <= ST_FINISH;
        end
        ST_LOCATE: if (loc_hs) begin
          if (loc_fail) begin
            fail_q <= 1'b1;
            state  <= ST_FINISH;
          end else begin
            if (fx.ok) cnt    <= cnt + 1'b1;
            else       fail_q <= 1'b1;
            if (loc_last) state <= ST_FINISH;
          end
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sector_fixup_chk.sv
module sector_fixup_chk import sfx_pkg::*; (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          loc_valid,
  input logic          loc_ready,
  input logic          loc_fail,
  input logic          fix_we,
  input logic [AW-1:0] mem_waddr,
  input logic [AW-1:0] limit
);
  p_ready_in_locate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    loc_ready |-> busy);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_fail_beat_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_valid && loc_ready && loc_fail) |=> !loc_ready);

  p_flip_in_span_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fix_we |-> (mem_waddr < limit));

  p_start_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

bind sector_fixup sector_fixup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .loc_valid(loc_valid), .loc_ready(loc_ready), .loc_fail(loc_fail),
  .fix_we(fix_we), .mem_waddr(mem_waddr), .limit(limit)
);

// File: tb/tb_sector_fixup.sv
module tb_sector_fixup;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 538;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_t16 = 1'b0;
  logic        host_we = 1'b0;
  logic [9:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [9:0]  host_raddr = '0;
  logic [7:0]  host_rdata;
  logic        calc_we = 1'b0;
  logic [4:0]  calc_idx = '0;
  logic [7:0]  calc_wdata = '0;
  logic [4:0]  rev_idx = '0;
  logic [7:0]  rev_byte;
  logic        start = 1'b0;
  logic        busy;
  logic        loc_valid = 1'b0;
  logic        loc_ready;
  logic [12:0] loc_value = '0;
  logic        loc_last = 1'b0;
  logic        loc_fail = 1'b0;
  logic        done;
  logic [12:0] flips;
  logic        fail;

  int n_checks = 0;
  int n_fails = 0;
  bit finished = 0;
  logic [7:0] model [DEPTH];
  int got_flips;
  bit got_fail;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_fixup dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic host_write(input int a, input logic [7:0] v);
    @(negedge clk);
    host_we = 1'b1; host_addr = 10'(a); host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic load_model();
    @(negedge clk);
    for (int a = 0; a < DEPTH; a++) begin
      host_we = 1'b1; host_addr = 10'(a); host_wdata = model[a];
      @(negedge clk);
    end
    host_we = 1'b0;
  endtask

  task automatic set_calc(input logic [7:0] pat, input int nz_idx);
    @(negedge clk);
    for (int i = 0; i < 26; i++) begin
      calc_we = 1'b1; calc_idx = 5'(i);
      calc_wdata = (pat == 8'h00) ? ((i == nz_idx) ? 8'h55 : 8'h00) : 8'(i + 1);
      @(negedge clk);
    end
    calc_we = 1'b0;
  endtask

  task automatic compare_buf(input string req);
    int bad = 0;
    int first_a = -1;
    logic [7:0] fa = '0;
    logic [7:0] fe = '0;
    for (int a = 0; a < DEPTH; a++) begin
      host_raddr = 10'(a);
      #1;
      if (host_rdata !== model[a]) begin
        if (first_a < 0) begin first_a = a; fa = host_rdata; fe = model[a]; end
        bad++;
      end
    end
    if (bad != 0) $display("  buffer byte %0d differs", first_a);
    check(bad == 0, req, int'(fa), int'(fe));
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (done !== 1'b1 && t < 5000) begin @(negedge clk); t++; end
    got_flips = int'(flips);
    got_fail = fail;
    @(negedge clk);
  endtask

  task automatic send_loc(input int v, input bit last, input bit f);
    int t = 0;
    loc_valid = 1'b1; loc_value = 13'(v); loc_last = last; loc_fail = f;
    while (loc_ready !== 1'b1 && t < 100) begin @(negedge clk); t++; end
    @(negedge clk);
    loc_valid = 1'b0; loc_last = 1'b0; loc_fail = 1'b0;
  endtask

  task automatic fill_model(input bit ff);
    for (int a = 0; a < DEPTH; a++) model[a] = ff ? 8'hFF : 8'((a * 7 + 3) & 8'hFF);
  endtask

  task automatic t_reset();
    check(busy == 0 && done == 0 && loc_ready == 0, "R1 idle outputs", int'({busy, done, loc_ready}), 0);
    check(flips == 0 && fail == 0, "R1 result outputs", int'(flips), 0);
  endtask

  task automatic t_clean_erased();
    mode_t16 = 1'b0;
    fill_model(1); load_model(); set_calc(8'h00, -1);
    pulse_start();
    check(loc_ready == 0, "R10 no ready on erased path", int'(loc_ready), 0);
    wait_done();
    check(got_flips == 0 && got_fail == 0, "R3 clean erased flips", got_flips, 0);
    compare_buf("R3 clean erased buffer");
  endtask

  task automatic t_erased_boundary8();
    mode_t16 = 1'b0;
    fill_model(1);
    model[0] = 8'hF0; model[525] = 8'hF0;
    load_model(); set_calc(8'h00, -1);
    pulse_start(); wait_done();
    check(got_flips == 8 && got_fail == 0, "R4 strength-8 count at limit", got_flips, 8);
    fill_model(1);
    compare_buf("R4 strength-8 forced to ones");
  endtask

  task automatic t_erased_over8();
    mode_t16 = 1'b0;
    fill_model(1);
    model[0] = 8'hF0; model[525] = 8'hF0; model[100] = 8'hFE;
    load_model(); set_calc(8'h00, -1);
    pulse_start(); wait_done();
    check(got_flips == 0 && got_fail == 0, "R5 over strength result", got_flips, 0);
    compare_buf("R5 over strength buffer kept");
  endtask

  task automatic t_erased16();
    mode_t16 = 1'b1;
    fill_model(1);
    model[3] = 8'hFE; model[300] = 8'hF9; model[532] = 8'h7E;
    load_model(); set_calc(8'h00, -1);
    pulse_start(); wait_done();
    check(got_flips == 5 && got_fail == 0, "R4 strength-16 count", got_flips, 5);
    fill_model(1);
    compare_buf("R4 strength-16 forced to ones");
  endtask

  task automatic t_reverse();
    set_calc(8'h01, -1);
    mode_t16 = 1'b0;
    rev_idx = 5'd0;  #1; check(rev_byte == 8'd13, "R6 rev8 idx0", int'(rev_byte), 13);
    rev_idx = 5'd12; #1; check(rev_byte == 8'd1, "R6 rev8 idx12", int'(rev_byte), 1);
    rev_idx = 5'd13; #1; check(rev_byte == 8'd14, "R6 rev8 reserved", int'(rev_byte), 14);
    mode_t16 = 1'b1;
    rev_idx = 5'd0;  #1; check(rev_byte == 8'd26, "R6 rev16 idx0", int'(rev_byte), 26);
    rev_idx = 5'd25; #1; check(rev_byte == 8'd1, "R6 rev16 idx25", int'(rev_byte), 1);
  endtask

  task automatic t_gate_reserved();
    mode_t16 = 1'b0;
    fill_model(1); load_model(); set_calc(8'h00, 13);
    pulse_start();
    check(loc_ready == 1, "R2 nonzero reserved byte enters location phase", int'(loc_ready), 1);
    send_loc(4199, 1, 0);
    wait_done();
    model[0] = 8'h7F;
    check(got_flips == 1 && got_fail == 0, "R2 single flip", got_flips, 1);
    compare_buf("R2 no erase fill");
  endtask

  task automatic t_locate8();
    mode_t16 = 1'b0;
    fill_model(0); load_model(); set_calc(8'h01, -1);
    pulse_start();
    host_write(5, 8'h00);
    send_loc(0, 0, 0);
    send_loc(4195, 0, 0);
    send_loc(111, 1, 0);
    wait_done();
    model[524] ^= 8'h01; model[0] ^= 8'h08; model[511] ^= 8'h80;
    check(got_flips == 3 && got_fail == 0, "R7 strength-8 flips", got_flips, 3);
    compare_buf("R7 R11 strength-8 buffer");
  endtask

  task automatic t_invalid8();
    mode_t16 = 1'b0;
    fill_model(0); load_model(); set_calc(8'h01, -1);
    pulse_start();
    send_loc(4200, 0, 0);
    send_loc(4199, 1, 0);
    wait_done();
    model[0] ^= 8'h80;
    check(got_flips == 1 && got_fail == 1, "R8 strength-8 span edge", got_flips + 100 * got_fail, 101);
    compare_buf("R8 strength-8 buffer");
  endtask

  task automatic t_locate16();
    mode_t16 = 1'b1;
    fill_model(0); load_model(); set_calc(8'h01, -1);
    pulse_start();
    send_loc(0, 0, 0);
    send_loc(4296, 0, 0);
    send_loc(4304, 0, 0);
    send_loc(200, 0, 0);
    send_loc(210, 1, 0);
    wait_done();
    model[537] ^= 8'h01; model[0] ^= 8'h01; model[512] ^= 8'h01; model[511] ^= 8'h04;
    check(got_flips == 4 && got_fail == 1, "R7 R8 strength-16 result", got_flips + 100 * got_fail, 104);
    compare_buf("R7 strength-16 buffer");
  endtask

  task automatic t_locfail();
    mode_t16 = 1'b0;
    fill_model(0); load_model(); set_calc(8'h01, -1);
    pulse_start();
    send_loc(8, 0, 0);
    send_loc(0, 0, 1);
    check(loc_ready == 0, "R9 list ended by failure beat", int'(loc_ready), 0);
    wait_done();
    model[523] ^= 8'h01;
    check(got_flips == 1 && got_fail == 1, "R9 failure result", got_flips + 100 * got_fail, 101);
    check(busy == 0 && flips == 13'd1 && fail == 1, "R10 results held after done", int'(flips), 1);
    compare_buf("R9 buffer");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_clean_erased();
    t_erased_boundary8();
    t_erased_over8();
    t_erased16();
    t_reverse();
    t_gate_reserved();
    t_locate8();
    t_invalid8();
    t_locate16();
    t_locfail();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule